// File: doc/BRIEF.md
# Indexed Word Load Unit

This unit executes one 32-bit instruction word at a time and supports two word loads. The first is the standard base-plus-offset load: a base register plus a sign-extended 12-bit immediate. The second is a custom load that adds two registers, a base and a byte index, and has no immediate. The unit holds a small register file with x0 wired to zero.

An accepted instruction moves through a fixed sequence of states:
- `ST_IDLE` waits for an instruction and accepts it while `instr_ready` is high.
- `ST_DECODE` decodes the word, reads the source registers and registers the effective address.
- `ST_LDMEM` holds a word read request on a valid/ready port until the memory answers.
- `ST_WRITEBACK` writes the returned word to the destination register.
- `ST_RETIRE` pulses `done` so the next instruction can be fetched.

A word that matches neither load takes the path `ST_DECODE` → `ST_ILLEGAL` → `ST_IDLE`. It raises `illegal` for one cycle and changes no state.

The named transitions are:
- IDLE→DECODE on `instr_valid`.
- DECODE→LDMEM for a legal load.
- DECODE→ILLEGAL for any other word.
- LDMEM→LDMEM while `mem_ready` is low.
- LDMEM→WRITEBACK on `mem_ready`.
- WRITEBACK→RETIRE unconditionally.
- RETIRE→IDLE unconditionally.
- ILLEGAL→IDLE unconditionally.

The register file starts at zero after reset. Software fills it with ordinary loads that use x0 as the base.

Top module: `idxload_unit`

## Requirements
- R1: The indexed load is recognised only when bits [6:0] = 0101011, bits [14:12] = 010 and bits [31:25] = 0000000. Any other value in those fields makes the word illegal.
- R2: The indexed load uses these register fields: destination in bits [11:7], base in bits [19:15] and index in bits [24:20]. The word 0x016A232B is an indexed load with destination x6, base x20 and index x22.
- R3: The indexed load's read address is base + index, taken modulo 2^32. The index is a byte offset and is not scaled.
- R4: The standard load is recognised by bits [6:0] = 0000011 with bits [14:12] = 010. Its address is the base register plus the sign-extended immediate in bits [31:20], taken modulo 2^32.
- R5: The whole 32-bit returned word is written to the destination register. During writeback, `wb_en` is high for one cycle and `wb_rd`/`wb_data` show the destination and the word.
- R6: An instruction is accepted on a clock edge where `instr_valid` and `instr_ready` are both high. `instr_ready` is high only in `ST_IDLE`. The read request appears two cycles after acceptance.
- R7: `mem_req_valid` and `mem_req_addr` stay stable until the cycle in which `mem_ready` is high, for any number of wait cycles.
- R8: Writes to x0 are discarded, and x0 always reads as zero.
- R9: `done` is high for exactly one cycle, in the cycle after writeback. `instr_ready` returns in the cycle after that.
- R10: An illegal word raises `illegal` for one cycle, two cycles after acceptance. It makes no memory request and no register write, and the unit then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Unit idle, word accepted on this edge |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | XLEN | Byte address of the read |
| mem_ready | input | 1 | Memory returns data this cycle |
| mem_rdata | input | XLEN | Read data, valid with `mem_ready` |
| wb_en | output | 1 | Register writeback cycle |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | XLEN | Word being written |
| done | output | 1 | Load retired |
| illegal | output | 1 | Unrecognised instruction |

## Verification
The bench builds the unit with its defaults: XLEN = 32 and 32 registers. At these values, 12-bit negative offsets and register sums that pass 2^32 produce addresses that wrap. The bench's memory model inserts between zero and twenty wait cycles per read, so the request-hold behaviour is exercised on every path. Register contents, including x0 and the registers around an illegal word, are read back by issuing indexed loads with x0 as the index and watching the request address.

// File: rtl/idxload_pkg.sv
package idxload_pkg;

    // Controller states, in the order an accepted load visits them.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DECODE    = 3'd1,
        ST_LDMEM     = 3'd2,
        ST_WRITEBACK = 3'd3,
        ST_RETIRE    = 3'd4,
        ST_ILLEGAL   = 3'd5
    } state_e;

    typedef enum logic [1:0] {
        KIND_BAD = 2'd0,
        KIND_LW  = 2'd1,
        KIND_LWX = 2'd2
    } kind_e;

    localparam int unsigned INSN_W = 32;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned IMM_W  = 12;

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_IDXLD  = 7'b0101011;
    localparam logic [2:0] F3_WORD    = 3'b010;
    localparam logic [6:0] F7_IDXLD   = 7'b0000000;

    typedef struct packed {
        kind_e                kind;
        logic [RIDX_W-1:0]    rd;
        logic [RIDX_W-1:0]    rs1;
        logic [RIDX_W-1:0]    rs2;
        logic [IMM_W-1:0]     imm;
    } dec_t;

endpackage

// File: rtl/idxload_decoder.sv
module idxload_decoder
    import idxload_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    always_comb begin
        opc = insn[6:0];
        f3  = insn[14:12];
        f7  = insn[31:25];

        dec.rd  = insn[11:7];
        dec.rs1 = insn[19:15];
        dec.rs2 = insn[24:20];
        dec.imm = insn[31:20];

        if (opc == OPC_LOAD && f3 == F3_WORD) begin
            dec.kind = KIND_LW;
        end else if (opc == OPC_IDXLD && f3 == F3_WORD && f7 == F7_IDXLD) begin
            dec.kind = KIND_LWX;
        end else begin
            dec.kind = KIND_BAD;
        end
    end

endmodule

// File: rtl/idxload_regfile.sv
module idxload_regfile #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREGS)-1:0] ra_a,
    output logic [XLEN-1:0]          rd_a,
    input  logic [$clog2(NREGS)-1:0] ra_b,
    output logic [XLEN-1:0]          rd_b,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [XLEN-1:0]          wd
);

    localparam int unsigned AW = $clog2(NREGS);

    logic [XLEN-1:0] regs_q [NREGS];

    // Entry zero is a constant; the others are individual registers.
    assign regs_q[0] = '0;

    generate
        for (genvar g = 1; g < NREGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                end else if (we && wa == AW'(g)) begin
                    regs_q[g] <= wd;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_a = regs_q[ra_a];
        rd_b = regs_q[ra_b];
    end

endmodule

// File: rtl/idxload_agu.sv
module idxload_agu
    import idxload_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             use_index,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  index,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  addr
);

    localparam int unsigned EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        offset  = use_index ? index : imm_ext;
        addr    = base + offset;   // carry out is dropped: wraps modulo 2^XLEN
    end

endmodule

// File: rtl/idxload_ctrl.sv
module idxload_ctrl
    import idxload_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   instr_valid,
    input  kind_e  kind,
    input  logic   mem_ready,
    output state_e state,
    output logic   instr_ready,
    output logic   cap_insn,
    output logic   cap_addr,
    output logic   cap_data,
    output logic   mem_valid,
    output logic   wb_en,
    output logic   done,
    output logic   illegal
);

    state_e state_q;
    state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (instr_valid) state_d = ST_DECODE;
            ST_DECODE:    state_d = (kind == KIND_BAD) ? ST_ILLEGAL : ST_LDMEM;
            ST_LDMEM:     if (mem_ready) state_d = ST_WRITEBACK;
            ST_WRITEBACK: state_d = ST_RETIRE;
            ST_RETIRE:    state_d = ST_IDLE;
            ST_ILLEGAL:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        instr_ready = 1'b0;
        cap_insn    = 1'b0;
        cap_addr    = 1'b0;
        cap_data    = 1'b0;
        mem_valid   = 1'b0;
        wb_en       = 1'b0;
        done        = 1'b0;
        illegal     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                instr_ready = 1'b1;
                cap_insn    = instr_valid;
            end
            ST_DECODE: begin
                cap_addr = (kind != KIND_BAD);
            end
            ST_LDMEM: begin
                mem_valid = 1'b1;
                cap_data  = mem_ready;
            end
            ST_WRITEBACK: wb_en   = 1'b1;
            ST_RETIRE:    done    = 1'b1;
            ST_ILLEGAL:   illegal = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/idxload_unit.sv
module idxload_unit
    import idxload_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              instr_ready,
    output logic              mem_req_valid,
    output logic [XLEN-1:0]   mem_req_addr,
    input  logic              mem_ready,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              wb_en,
    output logic [4:0]        wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              done,
    output logic              illegal
);

    localparam int unsigned AW = $clog2(NREGS);

    logic [INSN_W-1:0] insn_q;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   data_q;
    dec_t              dec;
    state_e            state;
    logic              cap_insn;
    logic              cap_addr;
    logic              cap_data;
    logic              wb_int;
    logic [XLEN-1:0]   rs1_val;
    logic [XLEN-1:0]   rs2_val;
    logic [XLEN-1:0]   ea;

    idxload_decoder u_dec (
        .insn (insn_q),
        .dec  (dec)
    );

    idxload_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .kind        (dec.kind),
        .mem_ready   (mem_ready),
        .state       (state),
        .instr_ready (instr_ready),
        .cap_insn    (cap_insn),
        .cap_addr    (cap_addr),
        .cap_data    (cap_data),
        .mem_valid   (mem_req_valid),
        .wb_en       (wb_int),
        .done        (done),
        .illegal     (illegal)
    );

    idxload_regfile #(
        .XLEN  (XLEN),
        .NREGS (NREGS)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (AW'(dec.rs1)),
        .rd_a  (rs1_val),
        .ra_b  (AW'(dec.rs2)),
        .rd_b  (rs2_val),
        .we    (wb_int),
        .wa    (AW'(dec.rd)),
        .wd    (data_q)
    );

    idxload_agu #(
        .XLEN (XLEN)
    ) u_agu (
        .use_index (dec.kind == KIND_LWX),
        .base      (rs1_val),
        .index     (rs2_val),
        .imm       (dec.imm),
        .addr      (ea)
    );

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (cap_insn) insn_q <= instr_word;
            if (cap_addr) addr_q <= ea;
            if (cap_data) data_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req_addr = addr_q;
        wb_en        = wb_int;
        wb_rd        = dec.rd;
        wb_data      = data_q;
    end

endmodule

// File: rtl/idxload_unit_chk.sv
module idxload_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic            instr_ready,
    input logic            mem_req_valid,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_ready,
    input logic            wb_en,
    input logic            done,
    input logic            illegal
);

    // R7: request held steady while memory stalls
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows writeback
    a_r9_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> done);

    // R10: illegal has no side effects and is one cycle
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && !mem_req_valid && !done));

    a_r10_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (!illegal && instr_ready));

    // R5: writeback only after a completed read
    a_r5_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_ready) |=> wb_en);

    // R6: exclusive phases
    a_r6_phases: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_ready, mem_req_valid, wb_en, done, illegal}));

endmodule

bind idxload_unit idxload_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_ready   (instr_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_ready     (mem_ready),
    .wb_en         (wb_en),
    .done          (done),
    .illegal       (illegal)
);

// File: tb/idxload_unit_tb.sv
module idxload_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        instr_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        wb_en;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;
    logic        done;
    logic        illegal;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [31:0] model_rf [32];

    always #5 clk = ~clk;

    idxload_unit dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr_word    (instr_word),
        .instr_ready   (instr_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_ready     (mem_ready),
        .mem_rdata     (mem_rdata),
        .wb_en         (wb_en),
        .wb_rd         (wb_rd),
        .wb_data       (wb_data),
        .done          (done),
        .illegal       (illegal)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] enc_lw(input int rd, input int rs1, input logic [11:0] imm);
        return {imm, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_lwx(input int rd, input int rs1, input int rs2);
        return {7'b0, 5'(rs2), 5'(rs1), 3'b010, 5'(rd), 7'b0101011};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Offer one word, then check every output cycle by cycle.
    task automatic run(input logic [31:0] w, input int waits, input string tag);
        logic [6:0]  opc;
        logic [2:0]  f3;
        logic [6:0]  f7;
        int          rd, rs1, rs2;
        bit          is_lw, is_lwx;
        logic [31:0] ea;
        opc = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
        rd = int'(w[11:7]); rs1 = int'(w[19:15]); rs2 = int'(w[24:20]);
        is_lw  = (opc == 7'b0000011) && (f3 == 3'b010);
        is_lwx = (opc == 7'b0101011) && (f3 == 3'b010) && (f7 == 7'b0);
        if (is_lwx) ea = model_rf[rs1] + model_rf[rs2];
        else        ea = model_rf[rs1] + {{20{w[31]}}, w[31:20]};

        @(negedge clk);
        chk({tag, " R6 ready idle"}, 32'(instr_ready), 32'd1);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = 32'hDEAD_BEEF;
        chk({tag, " R6 decode quiet"}, {28'd0, instr_ready, mem_req_valid, wb_en, illegal}, 32'd0);
        @(negedge clk);
        if (!(is_lw || is_lwx)) begin
            chk({tag, " R10/R1 illegal"}, {29'd0, illegal, mem_req_valid, wb_en}, 32'b100);
            @(negedge clk);
            chk({tag, " R10 back idle"}, {29'd0, illegal, instr_ready, done}, 32'b010);
            return;
        end
        for (int i = 0; i <= waits; i++) begin
            chk({tag, " R7 req valid"}, 32'(mem_req_valid), 32'd1);
            chk({tag, " R3/R4 addr"}, mem_req_addr, ea);
            mem_ready = (i == waits);
            mem_rdata = (i == waits) ? memf(ea) : 32'hBAD0_0000;
            @(negedge clk);
        end
        mem_ready = 1'b0;
        mem_rdata = '0;
        chk({tag, " R5 wb_en"}, {30'd0, wb_en, mem_req_valid}, 32'b10);
        chk({tag, " R5/R2 wb_rd"}, 32'(wb_rd), 32'(rd));
        chk({tag, " R5 wb_data"}, wb_data, memf(ea));
        if (rd != 0) model_rf[rd] = memf(ea);
        @(negedge clk);
        chk({tag, " R9 done"}, {30'd0, done, instr_ready}, 32'b10);
        @(negedge clk);
        chk({tag, " R9 done gone"}, {30'd0, done, instr_ready}, 32'b01);
    endtask

    // Read a register back: indexed load into x0 with x0 as the index.
    task automatic peek(input int r, input string tag);
        run(enc_lwx(0, r, 0), 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model_rf[i] = '0;
        repeat (3) @(negedge clk);
        chk("reset outputs", {27'd0, instr_ready, mem_req_valid, wb_en, done, illegal}, 32'b10000);
        rst_n = 1'b1;

        run(enc_lw(5, 0, 12'h050), 0, "R4 lw x5");
        run(enc_lw(6, 0, 12'hFFC), 2, "R4 lw neg imm");
        run(enc_lwx(7, 5, 6), 1, "R3 lwx wrap");
        run(enc_lw(20, 0, 12'h100), 0, "R4 lw x20");
        run(enc_lw(22, 0, 12'h7FF), 0, "R4 lw x22");
        run(32'h016A232B, 3, "R2 fixed word");
        run(enc_lw(8, 7, 12'h801), 1, "R4 lw base+neg");
        run(enc_lwx(9, 0, 22), 20, "R7 long stall");
        run(enc_lwx(10, 6, 6), 0, "R3 byte index");
        run(enc_lw(0, 5, 12'h004), 0, "R8 write x0");
        peek(0, "R8 x0 zero");
        run(enc_lwx(0, 0, 0) | 32'h0200_0000, 0, "R1 bad f7");
        run((enc_lwx(11, 5, 6) & ~32'h7000) | 32'h3000, 0, "R1 bad f3");
        run(32'h00628333, 0, "R10 alu op");
        run(enc_lw(12, 5, 12'h0) & ~32'h7000, 0, "R10 byte load");
        peek(5, "R10 x5 kept");
        peek(6, "R10 x6 kept");
        peek(6, "R10 x6 kept");
        peek(11, "R10 x11 untouched");
        peek(12, "R10 x12 untouched");

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            finished = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule